// File: doc/BRIEF.md
# Ramped Digital Volume and Mute Controller

This block holds the attenuation of each channel of a multichannel audio output path and moves it gradually instead of in jumps. Every channel has a target written by software in half-decibel units, and a mute bit. From these the block forms an effective target: full attenuation (127 dB) while muted, otherwise the register value. A per-channel current attenuation then walks toward that effective target, one eighth of a decibel per step.

The step interval is a number of sample strobes. It is chosen by a 2-bit rate field that all channels share. The current attenuation leaves the block as a 10-bit code in 0.125 dB units, for a later stage that turns it into a gain. A per-channel done flag shows that the channel has reached its effective target.

Each channel is a three-state machine:
- HOLD: current equals effective target.
- ATTEN: current is below the target and grows.
- RELEASE: current is above the target and shrinks.

The next state is chosen each cycle from the comparison of current and effective target:
- to_atten when the target is higher than the current value.
- to_release when it is lower.
- to_hold when they are equal.

A change of target during a ramp is therefore a direct transition between ATTEN and RELEASE.

Top module: `vol_ramp_ctrl`

## Requirements
- R1: After reset every channel's current code is 0. With a target of 0 and mute clear, every done flag is 1.
- R2: The target is 8 bits in 0.5 dB units. An unmuted channel settles at a current code equal to target×4 (0.125 dB units).
- R3: Targets above 254 are treated as 254, so no current code ever exceeds 1016.
- R4: At each step event the current code moves by exactly 1 toward the effective target. Between step events it does not change.
- R5: Rate codes 0, 1, 2 and 3 select 1, 4, 16 and 64 strobes per step. A shared counter holds the strobes seen since the last step. A strobe that brings the count to at least the interval is a step event and clears the count. Without strobes nothing moves.
- R6: A set mute bit drives that channel toward code 1016 at the selected rate.
- R7: Clearing the mute bit ramps the channel back to its register target at the same rate.
- R8: A channel's done flag is 1 exactly when its current code equals its effective target.
- R9: A target change in mid-ramp redirects the ramp from the present code, with no jump and no restart.
- R10: Channels are independent. One channel's target or mute does not alter another channel's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe per audio sample |
| rate_sel | input | 2 | Shared step-interval code |
| tgt_att | input | NCH*8 | Per-channel target, 0.5 dB units, channel c at bits [8c+7:8c] |
| mute | input | NCH | Per-channel mute request |
| cur_att | output | NCH*10 | Per-channel current code, 0.125 dB units, channel c at bits [10c+9:10c] |
| ramp_done | output | NCH | Per-channel current equals effective target |

## Verification
The hardest case to reach is a reversal in mid-ramp. It can come from a target change or from a mute toggle, and it may coincide with a change of rate code while the shared strobe counter is part-way through an interval.

Directed sequences reverse one channel mid-ramp. Long constrained-random runs then change targets, mute bits, rate codes and strobe density sparsely, so that ramps are often cut short. A cycle-accurate bench model of the strobe counter and of every channel's code is compared each cycle.

// File: rtl/vr_pkg.sv
package vr_pkg;

    typedef enum logic [1:0] {
        RATE_1  = 2'd0,
        RATE_4  = 2'd1,
        RATE_16 = 2'd2,
        RATE_64 = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        CH_HOLD    = 2'd0,
        CH_ATTEN   = 2'd1,
        CH_RELEASE = 2'd2
    } ch_state_e;

    // strobes per step: 4**code
    function automatic logic [7:0] rate_interval(input logic [1:0] code);
        return 8'd1 << {code, 1'b0};
    endfunction

endpackage

// File: rtl/vr_step_timer.sv
module vr_step_timer
    import vr_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_stb,
    input  logic [1:0] rate_sel,
    output logic       step_tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       interval;
    logic [7:0]       cnt_next;

    always_comb begin
        interval  = rate_interval(rate_sel);
        cnt_next  = 8'(cnt_q) + 8'd1;
        step_tick = sample_stb && (cnt_next >= interval);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_tick) begin
            cnt_q <= '0;
        end else if (sample_stb) begin
            cnt_q <= CNT_W'(cnt_next);
        end
    end

    AST_TICK_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |-> sample_stb); // R5

    AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        8'(cnt_q) < 8'd64); // R5

endmodule

// File: rtl/vr_channel.sv
module vr_channel
    import vr_pkg::*;
#(
    parameter int TGT_W   = 8,
    parameter int FRAC_SH = 2,
    parameter int TGT_MAX = 254,
    parameter int CUR_W   = TGT_W + FRAC_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_tick,
    input  logic [TGT_W-1:0] tgt,
    input  logic             mute,
    output logic [CUR_W-1:0] cur,
    output logic             done
);

    localparam logic [TGT_W-1:0] TGT_LIM  = TGT_W'(TGT_MAX);
    localparam logic [CUR_W-1:0] MAX_CODE = CUR_W'(TGT_MAX << FRAC_SH);

    ch_state_e        state_q, state_d;
    logic [CUR_W-1:0] cur_q;
    logic [TGT_W-1:0] tgt_cl;
    logic [CUR_W-1:0] eff;

    always_comb begin
        tgt_cl = (tgt > TGT_LIM) ? TGT_LIM : tgt;
        eff    = mute ? MAX_CODE : (CUR_W'(tgt_cl) << FRAC_SH);
    end

    // transitions: to_atten / to_release / to_hold
    always_comb begin
        if (eff > cur_q) begin
            state_d = CH_ATTEN;
        end else if (eff < cur_q) begin
            state_d = CH_RELEASE;
        end else begin
            state_d = CH_HOLD;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (step_tick) begin
            unique case (state_d)
                CH_ATTEN:   cur_q <= cur_q + 1'b1;
                CH_RELEASE: cur_q <= cur_q - 1'b1;
                CH_HOLD:    cur_q <= cur_q;
                default:    cur_q <= cur_q;
            endcase
        end
    end

    always_comb begin
        cur  = cur_q;
        done = (state_d == CH_HOLD);
    end

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q >= $past(cur_q)) ? (cur_q - $past(cur_q)) : ($past(cur_q) - cur_q)) <= CUR_W'(1)); // R4

    AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(cur_q)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= MAX_CODE); // R3

    AST_MUTE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && step_tick && cur_q < MAX_CODE) |=> (cur_q > $past(cur_q))); // R6

    AST_HOLD_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_q == CH_HOLD && $stable(eff)) |-> done); // R8

endmodule

// File: rtl/vol_ramp_ctrl.sv
module vol_ramp_ctrl
    import vr_pkg::*;
#(
    parameter int NCH     = 6,
    parameter int TGT_W   = 8,
    parameter int FRAC_SH = 2,
    parameter int TGT_MAX = 254
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_stb,
    input  logic [1:0]                   rate_sel,
    input  logic [NCH*TGT_W-1:0]         tgt_att,
    input  logic [NCH-1:0]               mute,
    output logic [NCH*(TGT_W+FRAC_SH)-1:0] cur_att,
    output logic [NCH-1:0]               ramp_done
);

    localparam int CUR_W = TGT_W + FRAC_SH;

    logic step_tick;

    vr_step_timer #(.CNT_W(7)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_stb(sample_stb),
        .rate_sel  (rate_sel),
        .step_tick (step_tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        vr_channel #(
            .TGT_W  (TGT_W),
            .FRAC_SH(FRAC_SH),
            .TGT_MAX(TGT_MAX),
            .CUR_W  (CUR_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_tick(step_tick),
            .tgt      (tgt_att[c*TGT_W +: TGT_W]),
            .mute     (mute[c]),
            .cur      (cur_att[c*CUR_W +: CUR_W]),
            .done     (ramp_done[c])
        );
    end

    AST_MUTE_DONE_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (mute[0] && ramp_done[0]) |-> (cur_att[CUR_W-1:0] == CUR_W'(TGT_MAX << FRAC_SH))); // R6

endmodule

// File: tb/sim_vol_ramp_ctrl.sv
module sim_vol_ramp_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int MAXC = 1016;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sample_stb = 1'b0;
    logic [1:0]          rate_sel = 2'd0;
    logic [NCH*8-1:0]    tgt_att = '0;
    logic [NCH-1:0]      mute = '0;
    logic [NCH*10-1:0]   cur_att;
    logic [NCH-1:0]      ramp_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int m_cur [NCH];
    int m_cnt;

    vol_ramp_ctrl #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .rate_sel(rate_sel),
        .tgt_att(tgt_att), .mute(mute), .cur_att(cur_att), .ramp_done(ramp_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff_of(int c);
        int t;
        t = int'(tgt_att[c*8 +: 8]);
        if (mute[c]) return MAXC;
        if (t > 254) t = 254;
        return t * 4;
    endfunction

    function automatic int act_cur(int c);
        return int'(cur_att[c*10 +: 10]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_edge();
        int iv;
        bit stp;
        if (!rst_n) begin
            m_cnt = 0;
            for (int c = 0; c < NCH; c++) m_cur[c] = 0;
            return;
        end
        iv = 1 << (2 * int'(rate_sel));
        stp = 0;
        if (sample_stb) begin
            if (m_cnt + 1 >= iv) begin stp = 1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end
        if (stp) begin
            for (int c = 0; c < NCH; c++) begin
                if (m_cur[c] < eff_of(c)) m_cur[c]++;
                else if (m_cur[c] > eff_of(c)) m_cur[c]--;
            end
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                chk(act_cur(c) == m_cur[c], "R4 model code", act_cur(c), m_cur[c]);
                chk(ramp_done[c] == (m_cur[c] == eff_of(c)), "R8 done flag",
                    int'(ramp_done[c]), int'(m_cur[c] == eff_of(c)));
            end
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic set_tgt(input int c, input int v);
        tgt_att[c*8 +: 8] = 8'(v);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        run(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            chk(act_cur(c) == 0, "R1 reset code", act_cur(c), 0);
            chk(ramp_done[c] == 1'b1, "R1 reset done", int'(ramp_done[c]), 1);
        end

        // R2 basic ramp at rate code 0, strobe every cycle
        sample_stb = 1'b1;
        set_tgt(0, 10);
        run(39);
        chk(act_cur(0) == 39, "R2 mid ramp", act_cur(0), 39);
        chk(ramp_done[0] == 1'b0, "R8 not done mid ramp", int'(ramp_done[0]), 0);
        run(1);
        chk(act_cur(0) == 40, "R2 settled", act_cur(0), 40);
        chk(ramp_done[0] == 1'b1, "R8 done at target", int'(ramp_done[0]), 1);

        // R3 clamp
        set_tgt(1, 255);
        run(1020);
        chk(act_cur(1) == MAXC, "R3 clamp", act_cur(1), MAXC);
        chk(act_cur(0) == 40, "R10 other channel kept", act_cur(0), 40);

        // R5 no strobe, no movement; then rate code 1
        sample_stb = 1'b0;
        set_tgt(2, 200);
        run(20);
        chk(act_cur(2) == 0, "R5 no strobe", act_cur(2), 0);
        sample_stb = 1'b1;
        rate_sel = 2'd1;
        run(8);
        chk(act_cur(2) == 2, "R5 rate code 1", act_cur(2), 2);
        rate_sel = 2'd3;
        run(64);
        chk(act_cur(2) == 3, "R5 rate code 3", act_cur(2), 3);
        rate_sel = 2'd0;
        run(800);
        chk(act_cur(2) == 800, "R2 settle 200", act_cur(2), 800);

        // R6 / R7 mute and release
        set_tgt(3, 20);
        run(80);
        mute[3] = 1'b1;
        run(935);
        chk(act_cur(3) == 1015, "R6 mute one short", act_cur(3), 1015);
        run(1);
        chk(act_cur(3) == MAXC, "R6 mute reached", act_cur(3), MAXC);
        mute[3] = 1'b0;
        run(936);
        chk(act_cur(3) == 80, "R7 unmute back", act_cur(3), 80);

        // R9 redirect mid-ramp
        set_tgt(4, 100);
        run(50);
        set_tgt(4, 5);
        run(10);
        chk(act_cur(4) == 40, "R9 redirect", act_cur(4), 40);
        run(20);
        chk(act_cur(4) == 20, "R9 redirect settled", act_cur(4), 20);
        chk(act_cur(5) == 0, "R10 idle channel untouched", act_cur(5), 0);

        // constrained random
        for (int i = 0; i < 40000; i++) begin
            sample_stb = ($urandom % 4) != 0;
            if ($urandom % 150 == 0) set_tgt($urandom % NCH, $urandom % 256);
            if ($urandom % 400 == 0) mute[$urandom % NCH] ^= 1'b1;
            if ($urandom % 1500 == 0) rate_sel = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
            cycle();
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule